// File: doc/BRIEF.md
# Two-Line EPROM Read Controller

This block is a synchronous master that fetches single bytes from a bank of byte-wide parallel EPROMs. The bank shares one address bus, one data bus and one output-enable line; each device has its own chip-enable line. The host presents a request whose upper bits pick the device and whose lower bits give the word address. The controller drives the address, pulls the chosen chip enable low, and later pulls the shared output enable low. It waits until the address, chip-enable and output-enable access limits have all expired, captures the byte, and raises both controls again.

Every access limit is a parameter counted in clock cycles: address access, chip-enable access, output-enable access and output float time. The shared output enable falls only after the address access time minus the output-enable access time has passed. This keeps the output drivers off for as long as possible. Devices that are not selected stay in standby, so their outputs stay off whatever level the output enable has. When the next access goes to a different device, the output enable stays high until the float time of the previously driving device has run out. This prevents two devices from driving the data bus at the same time.

The host handshake is simple. A request is taken only while the busy flag is low. A one-cycle acknowledge returns the captured byte.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is held, every chip enable and the output enable are high (inactive), busy and acknowledge are low, and the returned byte is zero.
- R2: A request seen while busy is low is accepted at that clock edge. From the next cycle, the word address (request bits ADDR_W-1:0) is on the address bus, busy is high, and exactly one chip enable is low: the one whose index equals request bits DEV_W+ADDR_W-1:ADDR_W.
- R3: The single output enable shared by all devices is low only while some chip enable is low. It falls max(1, T_ACC - T_OE) cycles after the chip enable falls, where T_ACC = max(T_ADDR, T_CE), unless R6 delays it.
- R4: The byte is captured at the later of two edges: T_ACC cycles after the chip enable falls, and T_OE cycles after the output enable falls. In the cycle after that edge, acknowledge is high for exactly one cycle and the captured byte is returned.
- R5: At the capture edge the chip enable and the output enable both return high, and busy falls.
- R6: If an access selects a different device from the one last released, the output enable stays high for at least T_FLOAT cycles after that release. If the access selects the same device, it does not wait.
- R7: A request made while busy is high is ignored. The address, the chip enables and the returned byte of the access in progress are unchanged, and no extra acknowledge follows.
- R8: The address bus stays stable for as long as a chip enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Host read request |
| req_addr_i | input | DEV_W+ADDR_W | Device select (upper bits) and word address (lower bits) |
| busy_o | output | 1 | Access in progress; requests ignored |
| ack_o | output | 1 | One-cycle pulse; byte valid on rdata_o |
| rdata_o | output | DATA_W | Captured byte |
| rom_addr_o | output | ADDR_W | Address bus to the bank |
| rom_ce_n_o | output | NDEV | Per-device chip enables, active low |
| rom_oe_n_o | output | 1 | Shared output enable, active low |
| rom_data_i | input | DATA_W | Data bus from the bank |

## Verification
The bench's memory model returns a junk byte until the selected device has seen its chip enable and the output enable low for the full access times. A controller that captures one cycle too early therefore returns wrong data as well as a wrong acknowledge cycle.

The bench sends back-to-back accesses to different devices with gaps that land below, on and above the float boundary. A guard that is off by one, or missing, lets two devices drive at once, which a contention monitor counts. Back-to-back accesses to the same device must not be delayed.

Requests made during an access must leave the address and the selects untouched and must produce no second acknowledge. A controller that queued or accepted them would show a changed address or an extra pulse.

// File: rtl/erc_pkg.sv
package erc_pkg;

   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_ACCESS = 1'b1
   } erc_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/erc_cs_decode.sv
module erc_cs_decode #(
   parameter int NDEV  = 4,
   parameter int DEV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             drop_i,
   input  logic [DEV_W-1:0] sel_i,
   output logic [NDEV-1:0]  ce_n_o
);

   logic [NDEV-1:0] ce_n_q;
   logic [NDEV-1:0] ce_n_nxt;

   for (genvar i = 0; i < NDEV; i++) begin : g_sel
      assign ce_n_nxt[i] = (sel_i != DEV_W'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_n_q <= '1;
      end else if (load_i) begin
         ce_n_q <= ce_n_nxt;
      end else if (drop_i) begin
         ce_n_q <= '1;
      end
   end

   assign ce_n_o = ce_n_q;

   AST_CE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ce_n_q) <= 1); // R2

endmodule

// File: rtl/erc_access_timer.sv
module erc_access_timer #(
   parameter int T_ACC   = 50,
   parameter int T_OE    = 25,
   parameter int OE_LEAD = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   input  logic oe_allow_i,
   output logic oe_n_o,
   output logic ready_o
);

   localparam int CW = $clog2(T_ACC + T_OE + OE_LEAD + 2);
   localparam logic [CW-1:0] ACC_TH  = CW'(T_ACC - 1);
   localparam logic [CW-1:0] OEA_TH  = CW'(T_OE - 1);
   localparam logic [CW-1:0] LEAD_TH = CW'((OE_LEAD > 0) ? OE_LEAD - 1 : 0);
   localparam logic [CW-1:0] CNT_MAX = '1;

   logic          active_q;
   logic          oe_n_q;
   logic [CW-1:0] ce_cnt_q;
   logic [CW-1:0] oe_cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         oe_n_q   <= 1'b1;
         ce_cnt_q <= '0;
         oe_cnt_q <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         oe_n_q   <= 1'b1;
         ce_cnt_q <= '0;
         oe_cnt_q <= '0;
      end else if (stop_i) begin
         active_q <= 1'b0;
         oe_n_q   <= 1'b1;
      end else if (active_q) begin
         if (ce_cnt_q != CNT_MAX) begin
            ce_cnt_q <= ce_cnt_q + 1'b1;
         end
         if (oe_n_q) begin
            if ((ce_cnt_q >= LEAD_TH) && oe_allow_i) begin
               oe_n_q   <= 1'b0;
               oe_cnt_q <= '0;
            end
         end else if (oe_cnt_q != CNT_MAX) begin
            oe_cnt_q <= oe_cnt_q + 1'b1;
         end
      end
   end

   assign oe_n_o  = oe_n_q;
   assign ready_o = active_q && !oe_n_q && (ce_cnt_q >= ACC_TH) && (oe_cnt_q >= OEA_TH);

   AST_OE_AFTER_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_n_q) |-> (ce_cnt_q > LEAD_TH)); // R3

endmodule

// File: rtl/erc_float_guard.sv
module erc_float_guard #(
   parameter int DEV_W   = 2,
   parameter int T_FLOAT = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             release_i,
   input  logic [DEV_W-1:0] rel_dev_i,
   input  logic [DEV_W-1:0] cur_dev_i,
   output logic             oe_ok_o
);

   localparam int FW = $clog2(T_FLOAT + 2);

   logic [FW-1:0]    flt_q;
   logic [DEV_W-1:0] last_dev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flt_q      <= '0;
         last_dev_q <= '0;
      end else if (release_i) begin
         flt_q      <= FW'(T_FLOAT);
         last_dev_q <= rel_dev_i;
      end else if (flt_q != '0) begin
         flt_q <= flt_q - 1'b1;
      end
   end

   assign oe_ok_o = (flt_q <= FW'(1)) || (cur_dev_i == last_dev_q);

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl #(
   parameter int NDEV    = 4,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 8,
   parameter int T_ADDR  = 50,
   parameter int T_CE    = 50,
   parameter int T_OE    = 25,
   parameter int T_FLOAT = 15,
   localparam int DEV_W  = $clog2(NDEV)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_i,
   input  logic [DEV_W+ADDR_W-1:0] req_addr_i,
   output logic                    busy_o,
   output logic                    ack_o,
   output logic [DATA_W-1:0]       rdata_o,
   output logic [ADDR_W-1:0]       rom_addr_o,
   output logic [NDEV-1:0]         rom_ce_n_o,
   output logic                    rom_oe_n_o,
   input  logic [DATA_W-1:0]       rom_data_i
);
   import erc_pkg::*;

   localparam int T_ACC   = imax(T_ADDR, T_CE);
   localparam int OE_LEAD = imax(T_ACC - T_OE, 0);
   localparam int HA_W    = DEV_W + ADDR_W;
   localparam int GW      = $clog2(T_FLOAT + 2);

   if (NDEV < 2 || (NDEV & (NDEV - 1)) != 0) begin : g_bad_ndev
      $error("NDEV must be a power of two of at least 2");
   end
   if (T_ADDR < 1 || T_CE < 1 || T_OE < 1) begin : g_bad_timing
      $error("access times must be at least one cycle");
   end
   if (T_FLOAT < 0 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("float time must be non-negative and widths positive");
   end

   erc_state_e        state_q;
   logic [ADDR_W-1:0] word_q;
   logic [DEV_W-1:0]  sel_q;
   logic              ack_q;
   logic [DATA_W-1:0] rdata_q;
   logic              accept;
   logic              capture;
   logic              oe_ok;
   logic              oe_n;
   logic [NDEV-1:0]   ce_n;

   assign accept = req_i && (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         word_q  <= '0;
         sel_q   <= '0;
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q <= 1'b0;
         if (accept) begin
            state_q <= ST_ACCESS;
            word_q  <= req_addr_i[ADDR_W-1:0];
            sel_q   <= req_addr_i[HA_W-1:ADDR_W];
         end else if (capture) begin
            state_q <= ST_IDLE;
            rdata_q <= rom_data_i;
            ack_q   <= 1'b1;
         end
      end
   end

   erc_cs_decode #(.NDEV(NDEV), .DEV_W(DEV_W)) u_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .drop_i (capture),
      .sel_i  (req_addr_i[HA_W-1:ADDR_W]),
      .ce_n_o (ce_n)
   );

   erc_access_timer #(.T_ACC(T_ACC), .T_OE(T_OE), .OE_LEAD(OE_LEAD)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (accept),
      .stop_i     (capture),
      .oe_allow_i (oe_ok),
      .oe_n_o     (oe_n),
      .ready_o    (capture)
   );

   erc_float_guard #(.DEV_W(DEV_W), .T_FLOAT(T_FLOAT)) u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .release_i (capture),
      .rel_dev_i (sel_q),
      .cur_dev_i (sel_q),
      .oe_ok_o   (oe_ok)
   );

   assign busy_o     = (state_q == ST_ACCESS);
   assign ack_o      = ack_q;
   assign rdata_o    = rdata_q;
   assign rom_addr_o = word_q;
   assign rom_ce_n_o = ce_n;
   assign rom_oe_n_o = oe_n;

   // checker state: cycles since the last release, and which device it was
   logic [GW-1:0]    chk_gap_q;
   logic [DEV_W-1:0] chk_dev_q;
   logic             chk_vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_gap_q <= '0;
         chk_dev_q <= '0;
         chk_vld_q <= 1'b0;
      end else if (ack_q) begin
         chk_gap_q <= GW'(1);
         chk_dev_q <= sel_q;
         chk_vld_q <= 1'b1;
      end else if (chk_gap_q < GW'(T_FLOAT)) begin
         chk_gap_q <= chk_gap_q + 1'b1;
      end
   end

   AST_OE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_oe_n_o |-> (rom_ce_n_o != '1)); // R3
   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o); // R4
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (rom_ce_n_o == '1) && rom_oe_n_o && !busy_o); // R5
   AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rom_oe_n_o) && chk_vld_q && (sel_q != chk_dev_q)) |-> (chk_gap_q >= GW'(T_FLOAT))); // R6
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && req_i) |=> $stable(rom_addr_o)); // R7
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((rom_ce_n_o != '1) && $past(rom_ce_n_o != '1)) |-> $stable(rom_addr_o)); // R8

endmodule

// File: tb/eprom_rd_ctrl_tb_top.sv
module eprom_rd_ctrl_tb_top;

   localparam int NDEV    = 4;
   localparam int DEV_W   = 2;
   localparam int ADDR_W  = 12;
   localparam int DATA_W  = 8;
   localparam int T_ADDR  = 10;
   localparam int T_CE    = 12;
   localparam int T_OE    = 8;
   localparam int T_FLOAT = 9;
   localparam int T_ACC   = (T_ADDR > T_CE) ? T_ADDR : T_CE;
   localparam int LEAD    = (T_ACC > T_OE) ? T_ACC - T_OE : 0;
   localparam int OEMIN   = (LEAD > 1) ? LEAD : 1;

   // sel[21:20], word[19:8], idle gap[7:0]
   localparam logic [21:0] VEC [8] = '{
      {2'd0, 12'h000, 8'd2},
      {2'd0, 12'hFFF, 8'd0},
      {2'd1, 12'h123, 8'd0},
      {2'd3, 12'hABC, 8'd3},
      {2'd2, 12'h800, 8'd20},
      {2'd2, 12'h7FF, 8'd0},
      {2'd1, 12'h555, 8'd5},
      {2'd0, 12'h0AA, 8'd4}
   };

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic                    req_i;
   logic [DEV_W+ADDR_W-1:0] req_addr_i;
   logic                    busy_o;
   logic                    ack_o;
   logic [DATA_W-1:0]       rdata_o;
   logic [ADDR_W-1:0]       rom_addr_o;
   logic [NDEV-1:0]         rom_ce_n_o;
   logic                    rom_oe_n_o;
   logic [DATA_W-1:0]       rom_data_i = 8'h3C;

   always #2 clk = ~clk;

   eprom_rd_ctrl #(
      .NDEV(NDEV), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .T_ADDR(T_ADDR), .T_CE(T_CE), .T_OE(T_OE), .T_FLOAT(T_FLOAT)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_addr_i(req_addr_i),
      .busy_o(busy_o), .ack_o(ack_o), .rdata_o(rdata_o),
      .rom_addr_o(rom_addr_o), .rom_ce_n_o(rom_ce_n_o),
      .rom_oe_n_o(rom_oe_n_o), .rom_data_i(rom_data_i)
   );

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int ack_total = 0;
   int ack_exp = 0;
   int contention = 0;
   int oe_fall_cyc = -1;
   int prev_rel = 0;
   int prev_dev = 0;
   bit have_prev = 0;
   bit timed_out = 0;

   function automatic logic [7:0] rom_byte(input int d, input logic [11:0] w);
      return w[7:0] ^ {w[11:8], w[11:8]} ^ 8'(8'h5A + d * 33);
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // memory bank model and bus monitor, evaluated away from the active edge
   int               cec = 0;
   int               oec = 0;
   int               fl [NDEV];
   logic             prev_oe = 1'b1;
   logic [11:0]      prev_addr = '0;
   initial for (int d = 0; d < NDEV; d++) fl[d] = 0;

   always @(negedge clk) begin
      int dsel;
      dsel = -1;
      for (int d = 0; d < NDEV; d++) if (!rom_ce_n_o[d]) dsel = d;
      if (rom_ce_n_o == '1) cec = 0;
      else if (cec > 0 && rom_addr_o != prev_addr) cec = 1;
      else cec++;
      if (!rom_oe_n_o) oec++; else oec = 0;
      if (prev_oe && !rom_oe_n_o) oe_fall_cyc = cyc;
      prev_oe = rom_oe_n_o;
      if (ack_o) ack_total++;
      for (int d = 0; d < NDEV; d++) begin
         if (!rom_ce_n_o[d] && !rom_oe_n_o) fl[d] = T_FLOAT;
         else if (fl[d] > 0) fl[d]--;
      end
      for (int d = 0; d < NDEV; d++) begin
         if (!rom_ce_n_o[d] && !rom_oe_n_o) begin
            for (int e = 0; e < NDEV; e++) if (e != d && fl[e] > 0) contention++;
         end
      end
      if (dsel >= 0 && cec >= T_ACC && oec >= T_OE) rom_data_i = rom_byte(dsel, rom_addr_o);
      else rom_data_i = 8'h3C;
      prev_addr = rom_addr_o;
   end

   task automatic do_read(input int sel, input logic [11:0] w, input int gap, input bit intrude);
      int a, c, o_exp, c_exp;
      bit guarded;
      logic [NDEV-1:0] ce_exp;
      repeat (gap) @(negedge clk);
      req_i = 1'b1;
      req_addr_i = {DEV_W'(sel), w};
      @(negedge clk);
      a = cyc;
      req_i = 1'b0;
      ce_exp = ~(NDEV'(1) << sel);
      chk(rom_ce_n_o == ce_exp, "R2 chip enable select", rom_ce_n_o, ce_exp);
      chk(rom_addr_o == w, "R2 address driven", rom_addr_o, w);
      chk(busy_o == 1'b1, "R2 busy set", busy_o, 1);
      ack_exp++;
      o_exp = a + OEMIN;
      guarded = have_prev && (prev_dev != sel) && (prev_rel + T_FLOAT > o_exp);
      if (guarded) o_exp = prev_rel + T_FLOAT;
      c_exp = (o_exp + T_OE > a + T_ACC) ? o_exp + T_OE : a + T_ACC;
      if (intrude) begin
         for (int i = 0; i < 3; i++) begin
            req_i = 1'b1;
            req_addr_i = {DEV_W'((sel + 1) % NDEV), ~w};
            @(negedge clk);
            chk(rom_addr_o == w, "R7,R8 address held", rom_addr_o, w);
            chk(rom_ce_n_o == ce_exp, "R7 selects held", rom_ce_n_o, ce_exp);
         end
         req_i = 1'b0;
      end
      while (!ack_o) @(negedge clk);
      c = cyc;
      chk(c == c_exp, "R4 capture cycle", c - a, c_exp - a);
      if (guarded) chk(oe_fall_cyc == o_exp, "R6 output enable held by float guard", oe_fall_cyc - a, o_exp - a);
      else chk(oe_fall_cyc == o_exp, "R3 output enable lead", oe_fall_cyc - a, o_exp - a);
      chk(rdata_o == rom_byte(sel, w), "R4 returned byte", rdata_o, rom_byte(sel, w));
      chk(rom_ce_n_o == '1 && rom_oe_n_o && !busy_o, "R5 controls released", {rom_ce_n_o, rom_oe_n_o}, 5'h1F);
      prev_rel = c;
      prev_dev = sel;
      have_prev = 1'b1;
   endtask

   task automatic run_all();
      rst_n = 1'b0;
      req_i = 1'b0;
      req_addr_i = '0;
      repeat (3) @(negedge clk);
      chk(rom_ce_n_o == '1, "R1 chip enables idle", rom_ce_n_o, 15);
      chk(rom_oe_n_o == 1'b1, "R1 output enable idle", rom_oe_n_o, 1);
      chk(!busy_o && !ack_o, "R1 busy and ack low", {busy_o, ack_o}, 0);
      chk(rdata_o == '0, "R1 byte cleared", rdata_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         do_read(int'(VEC[i][21:20]), VEC[i][19:8], int'(VEC[i][7:0]), 1'b0);
      end
      do_read(1, 12'h321, 2, 1'b1);
      @(negedge clk);
      chk(!ack_o, "R4 acknowledge lasts one cycle", ack_o, 0);
      repeat (15) @(negedge clk);
      chk(ack_total == ack_exp, "R7 no extra acknowledge", ack_total, ack_exp);
      chk(busy_o == 1'b0, "R7 request while busy not queued", busy_o, 0);
      chk(contention == 0, "R6 no two devices driving", contention, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      end
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule